// File: doc/BRIEF.md
# Timing-State Control Sequencer

This block is the control unit of a small accumulator machine built around a single shared bus. A timing-state counter steps through a fixed six-tick fetch and then one or two execute ticks chosen by a 4-bit opcode. A combinational product-term plane turns the current tick, the opcode and the status flags into one-hot register-load strobes, one-hot bus-source selects, an ALU function code, a memory-address choice and the carry-flag source.

Every bus transfer passes through a transparent holding register T. The T load strobe is gated so that it is active only during the high half of the clock. The carry-flag load strobe is active only during the low half. Every other strobe stays on for the whole tick. The program counter advances through T: the incremented value is captured in T in one tick and written back in the next, because source and destination are the same register. A halt instruction parks the counter until an external button is pressed. The button is synchronized and edge-detected.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst_n` is low the counter is held at fetch tick 1, so the outputs show the memory-to-IR transfer and `halted_o` is 0. The first tick after release is fetch tick 1.
- R2: Fetch is six ticks in this order. IR load from memory (`ld_strobe_o` bit 0, `src_sel_o` bit 0). Increment into T (`src_sel_o` bit 1). T into PC (`ld_strobe_o` bit 2, `src_sel_o` bit 2). Operand B load from memory (`ld_strobe_o` bit 1). Increment into T. T into PC. Execution starts on tick 7.
- R3: `tmp_ld_o` is high only while `clk` is high, and `carry_ld_o` is high only while `clk` is low. `tmp_ld_o` is on for every tick that drives the bus from a source other than T.
- R4: `ld_strobe_o` (bits: 0 IR, 1 B, 2 PC, 3 ACC, 4 memory write) and `src_sel_o` (bits: 0 memory, 1 PC+1, 2 T, 3 B, 4 ACC, 5 ALU) are each one-hot or zero. They hold the same value over both halves of a tick.
- R5: Single-tick transfers. Opcode 0 loads the constant B into ACC. Opcode 1 loads memory at address B into ACC. Opcode 2 writes ACC to memory at address B. For opcodes 1 and 2, `mem_addr_b_o` is 1. Opcode 3 loads B into PC. Each of these returns to fetch tick 1.
- R6: Opcodes 9 to 14 (add with carry, subtract with carry, and, or, xor, shift right) take two execute ticks. In the first, the ALU result goes into T, with `alu_fn_o` equal to opcode minus 9. In the second, T is loaded into ACC. The carry is loaded in the first tick from the ALU (`carry_src_o`=0) for opcodes 9, 10 and 14 only.
- R7: Opcodes 4, 5 and 6 jump on zero, negative and carry. With the flag at 1 they load B into PC. With the flag at 0 the execute tick asserts no strobe. Either way the next tick is fetch tick 1.
- R8: Opcode 7 sets the carry and opcode 8 clears it. Each uses one execute tick with only `carry_ld_o` active and `carry_src_o` of 1 or 2 respectively.
- R9: Opcode 15 asserts nothing in its execute tick. The block then stays halted: `halted_o` is 1 and there are no load or source strobes.
- R10: A rising edge on `resume_btn_i` raised in a halted tick ends the halt after three ticks of latency and restarts fetch once. Holding the button has no further effect. An edge seen while running is discarded and does not end a later halt.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its level also gates the half-tick strobes |
| rst_n | input | 1 | Active-low asynchronous clear of the counter |
| opcode_i | input | 4 | Opcode held in IR, read in execute ticks |
| flag_zero_i | input | 1 | Zero flag |
| flag_neg_i | input | 1 | Negative flag |
| flag_carry_i | input | 1 | Carry flag |
| resume_btn_i | input | 1 | Asynchronous resume button |
| ld_strobe_o | output | 5 | One-hot register load / memory write strobes |
| src_sel_o | output | 6 | One-hot bus source select |
| mem_addr_b_o | output | 1 | Memory address from B (1) or PC (0) |
| alu_fn_o | output | 3 | ALU function code |
| tmp_ld_o | output | 1 | T load, high half of clock only |
| carry_ld_o | output | 1 | Carry load, low half of clock only |
| carry_src_o | output | 2 | Carry source: 0 ALU, 1 set, 2 clear |
| halted_o | output | 1 | Halt state indicator |

## Verification
The bench runs each conditional jump with its flag both set and clear. A design that mixed up the flag selection, or loaded PC on an untaken branch, would show a stray PC strobe or a missing one. Each tick is sampled in both clock halves, so a half-cycle strobe gated on the wrong level, or a full-cycle strobe that dropped mid-tick, shows up directly. The resume tests hold the button high through a following instruction and press it while running. A design without edge detection, or one that kept a stale press, would leave the next halt early or restart repeatedly. The three-tick resume latency is checked exactly.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    localparam int OPC_W   = 4;
    localparam int NUM_LD  = 5;
    localparam int NUM_SRC = 6;
    localparam int ALU_W   = 3;
    localparam int CY_W    = 2;

    // load strobe bit positions
    localparam int LD_IR  = 0;
    localparam int LD_B   = 1;
    localparam int LD_PC  = 2;
    localparam int LD_ACC = 3;
    localparam int LD_MEM = 4;

    // bus source bit positions
    localparam int SRC_MEM = 0;
    localparam int SRC_INC = 1;
    localparam int SRC_TMP = 2;
    localparam int SRC_B   = 3;
    localparam int SRC_ACC = 4;
    localparam int SRC_ALU = 5;

    localparam int ALU_BASE = 9;

    typedef enum logic [3:0] {
        TK_F1   = 4'd0,
        TK_F2   = 4'd1,
        TK_F3   = 4'd2,
        TK_F4   = 4'd3,
        TK_F5   = 4'd4,
        TK_F6   = 4'd5,
        TK_E1   = 4'd6,
        TK_E2   = 4'd7,
        TK_HALT = 4'd8
    } tick_e;

    typedef enum logic [OPC_W-1:0] {
        OP_LDC = 4'd0,
        OP_LDM = 4'd1,
        OP_STM = 4'd2,
        OP_JMP = 4'd3,
        OP_JZ  = 4'd4,
        OP_JN  = 4'd5,
        OP_JC  = 4'd6,
        OP_SEC = 4'd7,
        OP_CLC = 4'd8,
        OP_ADC = 4'd9,
        OP_SBC = 4'd10,
        OP_AND = 4'd11,
        OP_OR  = 4'd12,
        OP_XOR = 4'd13,
        OP_SHR = 4'd14,
        OP_HLT = 4'd15
    } opcode_e;

    typedef enum logic [CY_W-1:0] {
        CY_ALU  = 2'd0,
        CY_ONE  = 2'd1,
        CY_ZERO = 2'd2
    } cy_src_e;

    typedef struct packed {
        logic [NUM_LD-1:0]  ld;
        logic [NUM_SRC-1:0] src;
        logic               addr_b;
        logic [ALU_W-1:0]   alu_fn;
        logic               tmp_term;
        logic               cy_term;
        cy_src_e            cy_src;
        logic               two_step;
        logic               halt_req;
    } ctl_word_t;

endpackage

// File: rtl/ctl_resume_sync.sv
module ctl_resume_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic pulse_o
);

    localparam int CHAIN_W = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic               prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[CHAIN_W-2:0], btn_i};
        sync_d.prev  = sync_q.chain[CHAIN_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // one-tick pulse on the synchronized rising edge
    assign pulse_o = sync_q.chain[CHAIN_W-1] & ~sync_q.prev;

endmodule

// File: rtl/ctl_tick_counter.sv
module ctl_tick_counter
    import ctl_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  two_step_i,
    input  logic  halt_req_i,
    input  logic  resume_i,
    output tick_e tick_o
);

    typedef struct packed {
        tick_e tick;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (cnt_q.tick)
            TK_F1, TK_F2, TK_F3, TK_F4, TK_F5:
                cnt_d.tick = tick_e'(cnt_q.tick + 4'd1);
            TK_F6:
                cnt_d.tick = TK_E1;
            TK_E1: begin
                if (halt_req_i)      cnt_d.tick = TK_HALT;
                else if (two_step_i) cnt_d.tick = TK_E2;
                else                 cnt_d.tick = TK_F1;
            end
            TK_E2:
                cnt_d.tick = TK_F1;
            TK_HALT:
                cnt_d.tick = resume_i ? TK_F1 : TK_HALT;
            default:
                cnt_d.tick = TK_F1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{tick: TK_F1};
        else        cnt_q <= cnt_d;
    end

    assign tick_o = cnt_q.tick;

endmodule

// File: rtl/ctl_decode_plane.sv
module ctl_decode_plane
    import ctl_seq_pkg::*;
(
    input  tick_e             tick_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              flag_zero_i,
    input  logic              flag_neg_i,
    input  logic              flag_carry_i,
    output ctl_word_t         word_o
);

    opcode_e          op;
    logic [OPC_W-1:0] alu_idx;
    logic             jump_cond;

    assign op      = opcode_e'(opcode_i);
    assign alu_idx = opcode_i - OPC_W'(ALU_BASE);

    // flag term for the conditional jump group
    always_comb begin
        unique case (op)
            OP_JZ:   jump_cond = flag_zero_i;
            OP_JN:   jump_cond = flag_neg_i;
            OP_JC:   jump_cond = flag_carry_i;
            OP_JMP:  jump_cond = 1'b1;
            default: jump_cond = 1'b0;
        endcase
    end

    always_comb begin
        word_o        = '0;
        word_o.cy_src = CY_ALU;
        unique case (tick_i)
            TK_F1: begin
                word_o.src[SRC_MEM] = 1'b1;
                word_o.ld[LD_IR]    = 1'b1;
                word_o.tmp_term     = 1'b1;
            end
            TK_F4: begin
                word_o.src[SRC_MEM] = 1'b1;
                word_o.ld[LD_B]     = 1'b1;
                word_o.tmp_term     = 1'b1;
            end
            TK_F2, TK_F5: begin
                word_o.src[SRC_INC] = 1'b1;
                word_o.tmp_term     = 1'b1;
            end
            TK_F3, TK_F6: begin
                word_o.src[SRC_TMP] = 1'b1;
                word_o.ld[LD_PC]    = 1'b1;
            end
            TK_E1: begin
                unique case (op)
                    OP_LDC: begin
                        word_o.src[SRC_B]   = 1'b1;
                        word_o.ld[LD_ACC]   = 1'b1;
                        word_o.tmp_term     = 1'b1;
                    end
                    OP_LDM: begin
                        word_o.addr_b       = 1'b1;
                        word_o.src[SRC_MEM] = 1'b1;
                        word_o.ld[LD_ACC]   = 1'b1;
                        word_o.tmp_term     = 1'b1;
                    end
                    OP_STM: begin
                        word_o.addr_b       = 1'b1;
                        word_o.src[SRC_ACC] = 1'b1;
                        word_o.ld[LD_MEM]   = 1'b1;
                        word_o.tmp_term     = 1'b1;
                    end
                    OP_JMP, OP_JZ, OP_JN, OP_JC: begin
                        if (jump_cond) begin
                            word_o.src[SRC_B] = 1'b1;
                            word_o.ld[LD_PC]  = 1'b1;
                            word_o.tmp_term   = 1'b1;
                        end
                    end
                    OP_SEC: begin
                        word_o.cy_term = 1'b1;
                        word_o.cy_src  = CY_ONE;
                    end
                    OP_CLC: begin
                        word_o.cy_term = 1'b1;
                        word_o.cy_src  = CY_ZERO;
                    end
                    OP_ADC, OP_SBC, OP_SHR: begin
                        word_o.src[SRC_ALU] = 1'b1;
                        word_o.alu_fn       = alu_idx[ALU_W-1:0];
                        word_o.tmp_term     = 1'b1;
                        word_o.cy_term      = 1'b1;
                        word_o.two_step     = 1'b1;
                    end
                    OP_AND, OP_OR, OP_XOR: begin
                        word_o.src[SRC_ALU] = 1'b1;
                        word_o.alu_fn       = alu_idx[ALU_W-1:0];
                        word_o.tmp_term     = 1'b1;
                        word_o.two_step     = 1'b1;
                    end
                    OP_HLT: begin
                        word_o.halt_req = 1'b1;
                    end
                    default: ;
                endcase
            end
            TK_E2: begin
                word_o.src[SRC_TMP] = 1'b1;
                word_o.ld[LD_ACC]   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import ctl_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         opcode_i,
    input  logic               flag_zero_i,
    input  logic               flag_neg_i,
    input  logic               flag_carry_i,
    input  logic               resume_btn_i,
    output logic [4:0]         ld_strobe_o,
    output logic [5:0]         src_sel_o,
    output logic               mem_addr_b_o,
    output logic [2:0]         alu_fn_o,
    output logic               tmp_ld_o,
    output logic               carry_ld_o,
    output logic [1:0]         carry_src_o,
    output logic               halted_o
);

    tick_e     tick;
    ctl_word_t word;
    logic      resume_pulse;

    ctl_resume_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_i   (resume_btn_i),
        .pulse_o (resume_pulse)
    );

    ctl_tick_counter i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .two_step_i (word.two_step),
        .halt_req_i (word.halt_req),
        .resume_i   (resume_pulse),
        .tick_o     (tick)
    );

    ctl_decode_plane i_plane (
        .tick_i       (tick),
        .opcode_i     (opcode_i),
        .flag_zero_i  (flag_zero_i),
        .flag_neg_i   (flag_neg_i),
        .flag_carry_i (flag_carry_i),
        .word_o       (word)
    );

    assign ld_strobe_o  = word.ld;
    assign src_sel_o    = word.src;
    assign mem_addr_b_o = word.addr_b;
    assign alu_fn_o     = word.alu_fn;
    assign carry_src_o  = word.cy_src;
    assign halted_o     = (tick == TK_HALT);

    // half-tick strobes shaped by clock level
    assign tmp_ld_o   = word.tmp_term &  clk;
    assign carry_ld_o = word.cy_term  & ~clk;

endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] ld_strobe_o,
    input logic [5:0] src_sel_o,
    input logic       tmp_ld_o,
    input logic       carry_ld_o,
    input logic       halted_o
);

    always_comb begin
        assert_phase_excl_R3: assert (!(tmp_ld_o && carry_ld_o));
    end

    assert_ld_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_strobe_o));

    assert_src_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_sel_o));

    assert_ir_then_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe_o[0] |=> (src_sel_o == 6'b000010));

    assert_b_then_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe_o[1] |=> (src_sel_o == 6'b000010));

    assert_jump_refetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe_o[2] && src_sel_o[3]) |=> ld_strobe_o[0]);

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (ld_strobe_o == 5'd0 && src_sel_o == 6'd0));

    assert_resume_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted_o) |-> ld_strobe_o[0]);

endmodule

bind ctl_sequencer ctl_sequencer_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_strobe_o (ld_strobe_o),
    .src_sel_o   (src_sel_o),
    .tmp_ld_o    (tmp_ld_o),
    .carry_ld_o  (carry_ld_o),
    .halted_o    (halted_o)
);

// File: tb/test_ctl_sequencer.sv
`timescale 1ns/1ps
module test_ctl_sequencer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] opcode;
    logic       fz, fn, fc, btn;
    logic [4:0] ld;
    logic [5:0] src;
    logic       addr_b, tmp_ld, carry_ld, halted;
    logic [2:0] alu_fn;
    logic [1:0] cy_src;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    ctl_sequencer i_ctl_sequencer (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode),
        .flag_zero_i(fz), .flag_neg_i(fn), .flag_carry_i(fc),
        .resume_btn_i(btn), .ld_strobe_o(ld), .src_sel_o(src),
        .mem_addr_b_o(addr_b), .alu_fn_o(alu_fn), .tmp_ld_o(tmp_ld),
        .carry_ld_o(carry_ld), .carry_src_o(cy_src), .halted_o(halted)
    );

    function automatic logic [4:0] L(int i); return 5'(1) << i; endfunction
    function automatic logic [5:0] S(int i); return 6'(1) << i; endfunction
    function automatic logic [19:0] ew(logic [4:0] l, logic [5:0] s, logic ab,
        logic [2:0] a, logic t, logic c, logic [1:0] cs, logic h);
        return {l, s, ab, a, t, c, cs, h};
    endfunction

    task automatic chk(bit ok, string tag, logic [19:0] act, logic [19:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(logic [19:0] v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic push_fetch();
        push(ew(L(0), S(0), 0, 0, 1, 0, 0, 0), "R2");
        push(ew(0,    S(1), 0, 0, 1, 0, 0, 0), "R2");
        push(ew(L(2), S(2), 0, 0, 0, 0, 0, 0), "R2");
        push(ew(L(1), S(0), 0, 0, 1, 0, 0, 0), "R2");
        push(ew(0,    S(1), 0, 0, 1, 0, 0, 0), "R2");
        push(ew(L(2), S(2), 0, 0, 0, 0, 0, 0), "R2");
    endtask

    task automatic wait_ticks(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic run_op(int op, bit z, bit n, bit c);
        int ticks;
        opcode = 4'(op); fz = z; fn = n; fc = c;
        push_fetch();
        ticks = 7;
        case (op)
            0: push(ew(L(3), S(3), 0, 0, 1, 0, 0, 0), "R5");
            1: push(ew(L(3), S(0), 1, 0, 1, 0, 0, 0), "R5");
            2: push(ew(L(4), S(4), 1, 0, 1, 0, 0, 0), "R5");
            3: push(ew(L(2), S(3), 0, 0, 1, 0, 0, 0), "R5");
            4, 5, 6: begin
                bit f;
                f = (op == 4) ? z : (op == 5) ? n : c;
                if (f) push(ew(L(2), S(3), 0, 0, 1, 0, 0, 0), "R7");
                else   push(ew(0, 0, 0, 0, 0, 0, 0, 0), "R7");
            end
            7: push(ew(0, 0, 0, 0, 0, 1, 1, 0), "R8");
            8: push(ew(0, 0, 0, 0, 0, 1, 2, 0), "R8");
            default: begin
                bit cy;
                cy = (op == 9 || op == 10 || op == 14);
                push(ew(0, S(5), 0, 3'(op - 9), 1, cy, 0, 0), "R6");
                push(ew(L(3), S(2), 0, 0, 0, 0, 0, 0), "R6");
                ticks = 8;
            end
        endcase
        wait_ticks(ticks);
    endtask

    // halt, stay for pre ticks, then press; three more halted ticks follow
    task automatic run_hlt(int pre);
        opcode = 4'd15;
        push_fetch();
        push(ew(0, 0, 0, 0, 0, 0, 0, 0), "R9");
        for (int i = 0; i < pre + 3; i++)
            push(ew(0, 0, 0, 0, 0, 0, 0, 1), (i < pre) ? "R9" : "R10");
        wait_ticks(7 + pre);
        btn = 1'b1;
        wait_ticks(3);
    endtask

    // monitor: sample each tick in the high and the low half
    initial begin
        logic [4:0] ld_h, ld_l;
        logic [5:0] src_h, src_l;
        logic       ab_h, tmp_h, tmp_l, cy_h, cy_l, hl_h;
        logic [2:0] alu_h;
        logic [1:0] cs_h;
        logic [19:0] act, e;
        string t;
        @(posedge rst_n);
        forever begin
            #3;
            ld_h = ld; src_h = src; ab_h = addr_b; alu_h = alu_fn;
            tmp_h = tmp_ld; cy_h = carry_ld; cs_h = cy_src; hl_h = halted;
            #10;
            ld_l = ld; src_l = src; tmp_l = tmp_ld; cy_l = carry_ld;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = {ld_h, src_h, ab_h, alu_h, tmp_h, cy_l, cs_h, hl_h};
                chk(act == e, t, act, e);
                chk(!tmp_l && !cy_h, "R3", {18'd0, tmp_l, cy_h}, 20'd0);
                chk(ld_l == ld_h && src_l == src_h, "R4",
                    {9'd0, ld_l, src_l}, {9'd0, ld_h, src_h});
            end
            @(posedge clk);
            #2;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; btn = 1'b0; opcode = 4'd0; fz = 0; fn = 0; fc = 0;
        repeat (3) @(posedge clk);
        #5;
        // R1: held in fetch tick 1 during reset
        chk({ld, src, tmp_ld, halted} == {L(0), S(0), 1'b1, 1'b0}, "R1",
            20'({ld, src, tmp_ld, halted}), 20'({L(0), S(0), 1'b1, 1'b0}));
        @(posedge clk);
        #2 rst_n = 1'b1;

        run_op(0, 0, 0, 0);  // R1 first tick after release is fetch tick 1
        run_op(1, 0, 0, 0);
        run_op(2, 0, 0, 0);
        run_op(3, 0, 0, 0);
        run_op(4, 1, 0, 0);
        run_op(4, 0, 1, 1);
        run_op(5, 0, 1, 0);
        run_op(5, 1, 0, 1);
        run_op(6, 0, 0, 1);
        run_op(6, 1, 1, 0);
        run_op(7, 0, 0, 0);
        run_op(8, 0, 0, 0);
        for (int op = 9; op <= 14; op++) run_op(op, 0, 0, 0);

        run_hlt(4);          // R9 / R10
        run_op(9, 0, 0, 0);  // R10 button still held: no effect
        btn = 1'b0;
        run_op(0, 0, 0, 0);
        btn = 1'b1;          // R10 press while running is discarded
        run_op(3, 0, 0, 0);
        run_op(12, 0, 0, 0);
        btn = 1'b0;
        run_op(0, 0, 0, 0);
        run_hlt(2);
        btn = 1'b0;
        run_op(13, 0, 0, 0);

        wait (exp_q.size() == 0);
        @(posedge clk);
        #15;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule